// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns a stream of frame bytes into a synchronous HDLC serial line. Bytes arrive over a ready/valid interface, each one marked as the first or the last of its frame. The block sends an opening flag, then the frame octets least significant bit first, then the complemented CRC register most significant bit first, then a closing flag. Between the flags it inserts a zero after any five consecutive ones, so the flag pattern never appears inside a frame. When no frame is pending, the line carries back-to-back flags.

The bit timing comes from outside the block. A one-cycle strobe, `bit_en`, arrives from an external bit clock, and the block presents exactly one new line bit per strobe. The check sequence is either 16 or 32 bits long. The width is sampled once per frame, when the frame starts. If the source runs dry in the middle of a frame, the block abandons the frame with a run of ones and then returns to idle flags.

Top module: `hdlc_tx`

## Requirements
- R1: While `rst` is high, `tx_bit` is 1. After `rst` falls, `in_ready` is 1 and `tx_bit` stays 1 until the first strobe.
- R2: When no frame is pending, the line carries repeated flags 0x7E, each sent least significant bit first (time order 0,1,1,1,1,1,1,0). A frame starts only after a whole flag.
- R3: Between the opening flag and the closing flag, a 0 is inserted after every five consecutive 1s, so no run of six 1s appears in the frame body. Stuffed zeros do not enter the CRC.
- R4: Each frame octet is sent least significant bit first, in the order the octets were accepted.
- R5: With `crc32_sel`=0 at frame start, the check sequence is 16 bits. Polynomial 0x1021, register preset to all ones, fed with the unstuffed octet bits in line order. The register is complemented and sent most significant bit first.
- R6: With `crc32_sel`=1 at frame start, the check sequence is 32 bits with polynomial 0x04C11DB7, handled the same way as in R5. Changes to `crc32_sel` after the frame has started have no effect on that frame.
- R7: A closing flag follows the check sequence. The flag itself is never stuffed, but a pending stuffed zero is inserted before it.
- R8: If no next byte is held when the current octet's last bit has gone out and that octet did not carry `in_eof`, the block sends eight 1s and then returns to idle flags.
- R9: `tx_bit` changes only in the clock cycle after a cycle in which `bit_en` is 1.
- R10: A byte is taken in a cycle with `in_valid` and `in_ready` both 1. `in_ready` is 0 in the cycle after any accept, and while a stuffed zero, the check sequence, a closing flag or an abort is being sent.
- R11: A byte accepted while idle that lacks `in_sof` is discarded and appears in no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe: send the next line bit |
| crc32_sel | input | 1 | Check sequence width for the next frame: 0 gives 16 bits, 1 gives 32 bits |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | `in_data` and its markers are valid |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Block can take a byte this cycle |
| tx_bit | output | 1 | Serial line bit, registered |

## Verification
The assertions check several rules on every cycle. No body bit extends a run of ones beyond five. The line holds still between strobes. Every bit tagged as abort is a one. Ready falls right after any accept. The bench decodes the line with its own receiver model, which finds flags, strips stuffed zeros and spots aborts. Only its scenarios can show that octet order, bit order, check sequence values, the per-frame width latch, discarding of stray bytes and the abort on underrun are correct end to end.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_DATA, ST_FCS, ST_CLOSE, ST_ABORT} tx_st_t;

  // tag carried alongside every line bit (consumed by the checker)
  localparam logic [1:0] K_NONE  = 2'd0;
  localparam logic [1:0] K_FLAG  = 2'd1;
  localparam logic [1:0] K_BODY  = 2'd2;
  localparam logic [1:0] K_ABORT = 2'd3;

  localparam logic [7:0]  FLAG_PAT = 8'h7E;
  localparam logic [31:0] POLY_WIDE = 32'h04C1_1DB7;
  localparam logic [15:0] POLY_NARROW = 16'h1021;
endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
  import hdlc_tx_pkg::*;
#(
  parameter int CRC_MAX = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init,
  input  logic               step,
  input  logic               din,
  input  logic               wide,
  output logic [CRC_MAX-1:0] crc_q
);
  localparam int NARROW = 16;

  logic               fb;
  logic [CRC_MAX-1:0] shifted;
  logic [CRC_MAX-1:0] nxt;

  always_comb begin
    fb      = (wide ? crc_q[CRC_MAX-1] : crc_q[NARROW-1]) ^ din;
    shifted = {crc_q[CRC_MAX-2:0], 1'b0};
    if (wide) nxt = shifted ^ (fb ? POLY_WIDE : '0);
    else      nxt = shifted ^ (fb ? CRC_MAX'(POLY_NARROW) : '0);
    if (!wide) nxt[CRC_MAX-1:NARROW] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= '0;
    else if (init) crc_q <= '1;
    else if (step) crc_q <= nxt;
  end
endmodule

// File: rtl/hdlc_tx_hold.sv
module hdlc_tx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] din,
  input  logic              sof,
  input  logic              eof,
  input  logic              valid,
  input  logic              allow,
  input  logic              take,
  output logic              ready,
  output logic              full,
  output logic [BYTE_W-1:0] q,
  output logic              q_sof,
  output logic              q_eof
);
  assign ready = allow && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      q     <= '0;
      q_sof <= 1'b0;
      q_eof <= 1'b0;
    end else if (valid && ready) begin
      full  <= 1'b1;
      q     <= din;
      q_sof <= sof;
      q_eof <= eof;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser
  import hdlc_tx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int CRC_MAX   = 32,
  parameter int ABORT_LEN = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               crc32_sel,
  input  logic               buf_full,
  input  logic [BYTE_W-1:0]  buf_data,
  input  logic               buf_sof,
  input  logic               buf_eof,
  input  logic [CRC_MAX-1:0] crc_q,
  output logic               buf_take,
  output logic               buf_allow,
  output logic               crc_init,
  output logic               crc_step,
  output logic               crc_din,
  output logic               crc_wide,
  output logic               tx_bit,
  output logic [1:0]         tx_kind
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int CIX   = $clog2(CRC_MAX);
  localparam int CNT_W = $clog2(CRC_MAX + ABORT_LEN + BYTE_W);
  localparam logic [CNT_W-1:0] BYTE_END  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ABORT_END = CNT_W'(ABORT_LEN - 1);

  tx_st_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  sreg;
  logic [2:0]         ones;
  logic               last;
  logic               stuff;
  logic               data_bit;
  logic               fcs_bit;
  logic [CIX-1:0]     fcs_idx;
  logic [CNT_W-1:0]   fcs_end;
  logic [2:0]         ones_nx;

  assign crc_wide = last_wide;
  logic last_wide;

  always_comb begin
    stuff    = (ones == 3'd5);
    data_bit = sreg[cnt[BIT_W-1:0]];
    fcs_end  = last_wide ? CNT_W'(CRC_MAX - 1) : CNT_W'(15);
    fcs_idx  = fcs_end[CIX-1:0] - cnt[CIX-1:0];
    fcs_bit  = ~crc_q[fcs_idx];
    crc_din  = data_bit;
    buf_take = 1'b0;
    crc_init = 1'b0;
    crc_step = 1'b0;
    buf_allow = (st == ST_IDLE) || (st == ST_DATA && !stuff);
    if (bit_en) begin
      if (st == ST_IDLE && cnt == BYTE_END && buf_full) begin
        buf_take = 1'b1;
        crc_init = buf_sof;
      end
      if (st == ST_DATA && !stuff) begin
        crc_step = 1'b1;
        if (cnt == BYTE_END && !last && buf_full) buf_take = 1'b1;
      end
    end
    ones_nx = 3'd0;
    if (st == ST_DATA && data_bit) ones_nx = ones + 3'd1;
    if (st == ST_FCS && fcs_bit)   ones_nx = ones + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sreg      <= '0;
      ones      <= 3'd0;
      last      <= 1'b0;
      last_wide <= 1'b0;
      tx_bit    <= 1'b1;
      tx_kind   <= K_NONE;
    end else if (bit_en) begin
      unique case (st)
        ST_IDLE: begin
          tx_bit  <= FLAG_PAT[cnt[2:0]];
          tx_kind <= K_FLAG;
          cnt     <= cnt + CNT_W'(1);
          if (cnt == BYTE_END) begin
            cnt <= '0;
            if (buf_full && buf_sof) begin
              st        <= ST_DATA;
              sreg      <= buf_data;
              last      <= buf_eof;
              ones      <= 3'd0;
              last_wide <= crc32_sel;
            end
          end
        end
        ST_DATA, ST_FCS: begin
          tx_kind <= K_BODY;
          if (stuff) begin
            tx_bit <= 1'b0;
            ones   <= 3'd0;
          end else begin
            tx_bit <= (st == ST_DATA) ? data_bit : fcs_bit;
            ones   <= ones_nx;
            cnt    <= cnt + CNT_W'(1);
            if (st == ST_DATA && cnt == BYTE_END) begin
              cnt <= '0;
              if (last)          st <= ST_FCS;
              else if (buf_full) begin
                sreg <= buf_data;
                last <= buf_eof;
              end else           st <= ST_ABORT;
            end
            if (st == ST_FCS && cnt == fcs_end) begin
              cnt <= '0;
              st  <= ST_CLOSE;
            end
          end
        end
        ST_CLOSE: begin
          if (stuff) begin
            tx_bit  <= 1'b0;
            tx_kind <= K_BODY;
            ones    <= 3'd0;
          end else begin
            tx_bit  <= FLAG_PAT[cnt[2:0]];
            tx_kind <= K_FLAG;
            cnt     <= cnt + CNT_W'(1);
            if (cnt == BYTE_END) begin
              cnt <= '0;
              st  <= ST_IDLE;
            end
          end
        end
        default: begin
          tx_bit  <= 1'b1;
          tx_kind <= K_ABORT;
          ones    <= 3'd0;
          cnt     <= cnt + CNT_W'(1);
          if (cnt == ABORT_END) begin
            cnt <= '0;
            st  <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
  import hdlc_tx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int CRC_MAX   = 32,
  parameter int ABORT_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              crc32_sel,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_ready,
  output logic              tx_bit
);
  logic               buf_full, buf_sof, buf_eof, buf_take, buf_allow;
  logic [BYTE_W-1:0]  buf_data;
  logic               crc_init, crc_step, crc_din, crc_wide;
  logic [CRC_MAX-1:0] crc_q;
  logic [1:0]         tx_kind;

  hdlc_tx_hold #(.BYTE_W(BYTE_W)) hold_i (
    .clk(clk), .rst(rst), .din(in_data), .sof(in_sof), .eof(in_eof),
    .valid(in_valid), .allow(buf_allow), .take(buf_take), .ready(in_ready),
    .full(buf_full), .q(buf_data), .q_sof(buf_sof), .q_eof(buf_eof)
  );

  hdlc_tx_crc #(.CRC_MAX(CRC_MAX)) crc_i (
    .clk(clk), .rst(rst), .init(crc_init), .step(crc_step), .din(crc_din),
    .wide(crc_wide), .crc_q(crc_q)
  );

  hdlc_tx_ser #(.BYTE_W(BYTE_W), .CRC_MAX(CRC_MAX), .ABORT_LEN(ABORT_LEN)) ser_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .crc32_sel(crc32_sel),
    .buf_full(buf_full), .buf_data(buf_data), .buf_sof(buf_sof), .buf_eof(buf_eof),
    .crc_q(crc_q), .buf_take(buf_take), .buf_allow(buf_allow), .crc_init(crc_init),
    .crc_step(crc_step), .crc_din(crc_din), .crc_wide(crc_wide),
    .tx_bit(tx_bit), .tx_kind(tx_kind)
  );
endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_en,
  input logic       tx_bit,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] tx_kind
);
  logic       en_d;
  logic [3:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d <= 1'b0;
      run  <= 4'd0;
    end else begin
      en_d <= bit_en;
      if (en_d) run <= tx_bit ? ((run == 4'd15) ? run : run + 4'd1) : 4'd0;
    end
  end

  // R3: a body one never extends a run already at five
  a_r3_body_run_max5: assert property (@(posedge clk) disable iff (rst)
    (en_d && tx_kind == 2'd2 && tx_bit) |-> (run < 4'd5));

  // R9: line holds between strobes
  a_r9_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
    !en_d |-> $stable(tx_bit));

  // R8: abort bits are ones
  a_r8_abort_is_ones: assert property (@(posedge clk) disable iff (rst)
    (tx_kind == 2'd3) |-> tx_bit);

  // R10: ready drops after an accept
  a_r10_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
endmodule

bind hdlc_tx hdlc_tx_chk chk_i (
  .clk(clk), .rst(rst), .bit_en(bit_en), .tx_bit(tx_bit),
  .in_valid(in_valid), .in_ready(in_ready), .tx_kind(tx_kind)
);

// File: tb/hdlc_tx_tb_top.sv
`timescale 1ns/1ps
module hdlc_tx_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic crc32_sel = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic in_ready, tx_bit;

  always #5 clk = ~clk;

  hdlc_tx dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .crc32_sel(crc32_sel),
    .in_data(in_data), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_ready(in_ready), .tx_bit(tx_bit)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // reference check sequence step per R5/R6
  function automatic logic [31:0] ref_step(logic [31:0] c, bit b, bit wide);
    logic fb;
    logic [31:0] r;
    fb = (wide ? c[31] : c[15]) ^ b;
    r  = c << 1;
    if (fb) r = r ^ (wide ? 32'h04C11DB7 : 32'h00001021);
    if (!wide) r[31:16] = 16'h0;
    return r;
  endfunction

  // expected frames
  logic [7:0] exp_data [64][16];
  int exp_len [64];
  bit exp_wide [64];
  int n_exp = 0;

  // receiver model
  bit rxb [1024];
  int nb = 0, ones = 0, rx_cmp = 0, rx_aborts = 0, rx_flags = 0, rx_stuffed = 0;
  bit in_frame = 0, last_ok = 0;
  int nsamp = 0;
  logic [7:0] first8 = 8'h00;
  int r9_bad = 0, r10_bad = 0;
  bit en_seen = 0, hs_seen = 0;
  logic last_tx = 1'b1;

  task automatic process_frame();
    int fi, w, len;
    bit ok_data;
    logic [31:0] c, rcv, expf;
    fi = rx_cmp;
    rx_cmp++;
    if (fi >= n_exp) begin
      chk(0, "R7 unexpected frame", fi, n_exp);
      return;
    end
    len = exp_len[fi];
    w = exp_wide[fi] ? 32 : 16;
    chk(nb == 8*len + w, "R7 frame bit count", nb, 8*len + w);
    last_ok = (nb == 8*len + w);
    if (nb != 8*len + w) return;
    ok_data = 1;
    for (int i = 0; i < len; i++) begin
      logic [7:0] by;
      for (int k = 0; k < 8; k++) by[k] = rxb[8*i + k];
      if (by != exp_data[fi][i]) ok_data = 0;
    end
    chk(ok_data, "R4 octet content/order", ok_data, 1);
    c = exp_wide[fi] ? 32'hFFFFFFFF : 32'h0000FFFF;
    for (int k = 0; k < 8*len; k++) c = ref_step(c, rxb[k], exp_wide[fi]);
    expf = exp_wide[fi] ? ~c : {16'h0, ~c[15:0]};
    rcv = 0;
    for (int k = 0; k < w; k++) rcv = (rcv << 1) | 32'(rxb[8*len + k]);
    chk(rcv == expf, exp_wide[fi] ? "R6 32-bit check sequence" : "R5 16-bit check sequence",
        rcv, expf);
    last_ok = last_ok && ok_data && (rcv == expf);
  endtask

  task automatic rx_bit(input logic b);
    if (b) begin
      ones++;
      if (ones == 7) begin
        if (in_frame) rx_aborts++;
        in_frame = 0;
      end else if (in_frame && nb < 1024) begin
        rxb[nb] = 1; nb++;
      end
    end else begin
      if (ones == 5) rx_stuffed++;
      else if (ones == 6) begin
        rx_flags++;
        if (in_frame) begin
          nb = nb - 7;
          if (nb > 0) process_frame();
        end
        in_frame = 1;
        nb = 0;
      end else if (in_frame && nb < 1024) begin
        rxb[nb] = 0; nb++;
      end
      ones = 0;
    end
  endtask

  always @(posedge clk) begin
    en_seen <= bit_en;
    hs_seen <= in_valid && in_ready;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (!en_seen && tx_bit !== last_tx) r9_bad++;
      if (hs_seen && in_ready) r10_bad++;
      if (en_seen) begin
        if (nsamp < 8) first8[nsamp] = tx_bit;
        nsamp++;
        rx_bit(tx_bit);
      end
    end
    last_tx = tx_bit;
  end

  // bit strobe generator with random spacing
  initial begin
    wait (!rst);
    forever begin
      @(negedge clk); bit_en = 1'b1;
      @(negedge clk); bit_en = 1'b0;
      repeat ($urandom_range(3, 1)) @(negedge clk);
    end
  end

  task automatic put_byte(input logic [7:0] d, input bit s, input bit e);
    @(negedge clk);
    in_data = d; in_sof = s; in_eof = e; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic wait_events(input int target);
    for (int i = 0; i < 20000; i++) begin
      if (rx_cmp + rx_aborts >= target) break;
      @(negedge clk);
    end
  endtask

  // pat: 0 random, 1 all ones, 2 ascending from '1'
  task automatic send_frame(input int len, input bit wide, input int pat,
                            input bit underrun, input bit flip);
    int fi, tgt;
    logic [7:0] d [16];
    tgt = rx_cmp + rx_aborts + 1;
    for (int i = 0; i < len; i++) begin
      if (pat == 1)      d[i] = 8'hFF;
      else if (pat == 2) d[i] = 8'h31 + 8'(i);
      else               d[i] = ($urandom_range(2, 0) == 0) ? 8'hFF : 8'($urandom);
    end
    if (!underrun) begin
      fi = n_exp;
      exp_len[fi] = len; exp_wide[fi] = wide;
      for (int i = 0; i < len; i++) exp_data[fi][i] = d[i];
      n_exp++;
    end
    crc32_sel = wide;
    for (int i = 0; i < len; i++) begin
      put_byte(d[i], i == 0, !underrun && i == len - 1);
      if (flip && i == 1) crc32_sel = !wide;
    end
    wait_events(tgt);
    crc32_sel = wide;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    chk(tx_bit == 1'b1, "R1 line high in reset", tx_bit, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(tx_bit == 1'b1, "R1 line high before first strobe", tx_bit, 1);
    repeat (80) @(negedge clk);
    chk(first8 == 8'h7E, "R2 first idle flag pattern", first8, 8'h7E);
    chk(rx_flags >= 2, "R2 repeated idle flags", rx_flags, 2);

    begin : directed
      int a0, c0;
      send_frame(1, 0, 0, 0, 0);
      send_frame(9, 0, 2, 0, 0);
      send_frame(9, 1, 2, 0, 0);
      send_frame(6, 0, 1, 0, 0);
      send_frame(6, 1, 1, 0, 0);
      chk(rx_stuffed > 0, "R3 stuffed zeros present", rx_stuffed, 1);
      send_frame(5, 0, 0, 0, 1);
      send_frame(5, 1, 0, 0, 1);
      chk(rx_cmp == n_exp, "R6 width latched at frame start", rx_cmp, n_exp);
      a0 = rx_aborts; c0 = rx_cmp;
      send_frame(3, 0, 0, 1, 0);
      chk(rx_aborts == a0 + 1, "R8 abort on underrun", rx_aborts, a0 + 1);
      chk(rx_cmp == c0, "R8 aborted frame not delivered", rx_cmp, c0);
      repeat (60) @(negedge clk);
      chk(rx_flags > 0 && ones < 7, "R8 back to idle flags", ones, 0);
      put_byte(8'hA5, 0, 0);
      send_frame(4, 0, 0, 0, 0);
      chk(last_ok && rx_cmp == n_exp, "R11 stray byte discarded", rx_cmp, n_exp);
      a0 = rx_aborts;
      send_frame(2, 1, 1, 1, 0);
      chk(rx_aborts == a0 + 1, "R8 abort on underrun 32-bit", rx_aborts, a0 + 1);
    end

    for (int f = 0; f < 14; f++)
      send_frame($urandom_range(12, 1), 1'($urandom_range(1, 0)), 0, 0, 0);

    chk(rx_cmp == n_exp, "R7 all frames delimited", rx_cmp, n_exp);
    chk(r9_bad == 0, "R9 line stable between strobes", r9_bad, 0);
    chk(r10_bad == 0, "R10 ready low after accept", r10_bad, 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule